// File: doc/BRIEF.md
# Serial Bootstrap RAM Loader

This block fills a 256-byte on-chip RAM with a program image that arrives one byte at a time from a serial receiver. It is used when the chip starts in its bootstrap operating mode. Once loading has been started, every byte the receiver presents is written to the next RAM location, beginning at address 0x00 and ending at address 0x FF. There is no length field and no terminator, because the image size is fixed by the address width.

When the byte for the top address has been written, the block raises a one-cycle handoff pulse. This pulse tells the processor to begin executing at address 0x0000. Outside an active load, received bytes have no effect. If the bootstrap mode input falls during a load, the load is abandoned without a handoff.

The bit-level serial receiver is not part of this block: it is seen as a byte-valid strobe with a data byte. The processor is not part of it either.

Top module: `boot_ram_loader`

## Requirements
- R0: While `rst` is high, and in the first cycle after it is released, `ram_we`, `busy` and `jump_pulse` are low.
- R1: A `start` pulse takes effect only when `boot_mode` is high and no load is in progress. `busy` rises in the cycle after `start` is sampled. With `boot_mode` low, `start` leaves `busy` low.
- R2: `busy` stays high from the cycle after an accepted start until the cycle of the handoff pulse.
- R3: The writes of one load go to consecutive addresses, starting at 0x00 and ending at 0xFF. Every accepted start begins again at 0x00.
- R4: A byte is accepted when `rx_valid` is high during a load. In the following cycle, `ram_we` is high for one clock, with `ram_wdata` equal to that byte and `ram_addr` equal to its slot. When no byte was accepted in the previous cycle, `ram_we` is low.
- R5: `jump_pulse` is high for exactly one cycle, namely the cycle after the write to address 0xFF. It is never high at any other time.
- R6: `busy` falls in the same cycle in which `jump_pulse` is high.
- R7: `rx_valid` does not cause a write while no load is in progress. This includes the cycle of the last write and the time after the handoff, until a new accepted start.
- R8: A `start` pulse during a load does not move the write address and does not restart the load.
- R9: If `boot_mode` is low in a load cycle before the final byte has been accepted, the load is abandoned. In the next cycle `busy` is low, no write occurs and no handoff pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| boot_mode | input | 1 | High while the chip is in bootstrap mode; enables loading |
| start | input | 1 | Pulse that begins a load |
| rx_valid | input | 1 | Received-byte strobe from the serial receiver |
| rx_data | input | DATA_W | Received byte |
| ram_addr | output | ADDR_W | RAM write address |
| ram_wdata | output | DATA_W | RAM write data |
| ram_we | output | 1 | RAM write enable, one clock per byte |
| busy | output | 1 | High while a load is in progress |
| jump_pulse | output | 1 | One-cycle request to start execution at address 0x0000 |

## Verification
The assertions check the following on every cycle:
- each write carries the byte and strobe of the previous cycle;
- the address sequence restarts at zero whenever `busy` rises;
- `busy` only rises after a start made in bootstrap mode;
- no write follows an idle cycle;
- the handoff pulse is one cycle long and follows only the write to 0xFF, with `busy` falling at the same moment;
- a mode drop ends a load without a pulse.

The bench scenarios show what no single-cycle property captures:
- a complete image arrives intact in RAM under random byte gaps;
- a start in mid-load is ignored;
- strays after the handoff, and during the final write, are ignored;
- after an abort, a fresh load begins again at address zero.

// File: rtl/boot_ldr_pkg.sv
package boot_ldr_pkg;

    // Default image geometry: 2**IMG_ADDR_W bytes of DATA_W bits.
    localparam int unsigned IMG_ADDR_W = 8;
    localparam int unsigned IMG_DATA_W = 8;

    // Loader sequencing states.
    typedef enum logic [1:0] {
        LD_IDLE = 2'd0,   // waiting for a start in bootstrap mode
        LD_FILL = 2'd1,   // accepting image bytes
        LD_TAIL = 2'd2    // final write on the RAM port, handoff next
    } ld_state_e;

    // One step of the sequencer: next state and the strobes it issues.
    typedef struct packed {
        ld_state_e nxt;
        logic      clear;   // reset the write pointer
        logic      accept;  // take the current byte
        logic      fire;    // request the handoff pulse
    } ld_step_t;

    function automatic ld_step_t ld_step(
        input ld_state_e cur,
        input logic      mode,
        input logic      go,
        input logic      byte_vld,
        input logic      at_end
    );
        ld_step_t s;
        s.nxt    = cur;
        s.clear  = 1'b0;
        s.accept = 1'b0;
        s.fire   = 1'b0;
        unique case (cur)
            LD_IDLE: begin
                if (mode && go) begin
                    s.nxt   = LD_FILL;
                    s.clear = 1'b1;
                end
            end
            LD_FILL: begin
                if (!mode) begin
                    s.nxt = LD_IDLE;
                end else if (byte_vld) begin
                    s.accept = 1'b1;
                    if (at_end) s.nxt = LD_TAIL;
                end
            end
            LD_TAIL: begin
                s.nxt  = LD_IDLE;
                s.fire = 1'b1;
            end
            default: s.nxt = LD_IDLE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ldr_addr_ctr.sv
module ldr_addr_ctr #(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              inc,
    output logic [ADDR_W-1:0] slot,
    output logic              at_end
);
    localparam logic [ADDR_W-1:0] LAST_SLOT = {ADDR_W{1'b1}};

    logic [ADDR_W-1:0] slot_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            slot_q <= '0;
        end else if (inc) begin
            slot_q <= slot_q + 1'b1;
        end
    end

    assign slot   = slot_q;
    assign at_end = (slot_q == LAST_SLOT);
endmodule

// File: rtl/ldr_ctrl.sv
module ldr_ctrl
    import boot_ldr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic boot_mode,
    input  logic start,
    input  logic rx_valid,
    input  logic at_end,
    output logic clear,
    output logic accept,
    output logic fire,
    output logic busy
);
    ld_state_e state_q;
    ld_step_t  step;

    always_comb begin
        step = ld_step(state_q, boot_mode, start, rx_valid, at_end);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LD_IDLE;
        end else begin
            state_q <= step.nxt;
        end
    end

    assign clear  = step.clear;
    assign accept = step.accept;
    assign fire   = step.fire;
    assign busy   = (state_q != LD_IDLE);
endmodule

// File: rtl/ldr_wr_port.sv
module ldr_wr_port #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] slot,
    input  logic [DATA_W-1:0] din,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_en
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= accept;
            if (accept) begin
                wr_addr <= slot;
                wr_data <= din;
            end
        end
    end
endmodule

// File: rtl/ldr_handoff.sv
module ldr_handoff (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic pulse
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pulse <= 1'b0;
        end else begin
            pulse <= fire;
        end
    end
endmodule

// File: rtl/boot_ram_loader.sv
module boot_ram_loader #(
    parameter int unsigned ADDR_W = boot_ldr_pkg::IMG_ADDR_W,
    parameter int unsigned DATA_W = boot_ldr_pkg::IMG_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boot_mode,
    input  logic              start,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              ram_we,
    output logic              busy,
    output logic              jump_pulse
);
    logic              clear;
    logic              accept;
    logic              fire;
    logic              at_end;
    logic [ADDR_W-1:0] slot;

    ldr_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .boot_mode (boot_mode),
        .start     (start),
        .rx_valid  (rx_valid),
        .at_end    (at_end),
        .clear     (clear),
        .accept    (accept),
        .fire      (fire),
        .busy      (busy)
    );

    ldr_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .clear  (clear),
        .inc    (accept),
        .slot   (slot),
        .at_end (at_end)
    );

    ldr_wr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .slot    (slot),
        .din     (rx_data),
        .wr_addr (ram_addr),
        .wr_data (ram_wdata),
        .wr_en   (ram_we)
    );

    ldr_handoff u_jump (
        .clk   (clk),
        .rst   (rst),
        .fire  (fire),
        .pulse (jump_pulse)
    );
endmodule

// File: rtl/boot_ram_loader_chk.sv
module boot_ram_loader_chk #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              boot_mode,
    input logic              start,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_data,
    input logic [ADDR_W-1:0] ram_addr,
    input logic [DATA_W-1:0] ram_wdata,
    input logic              ram_we,
    input logic              busy,
    input logic              jump_pulse
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

    // Checker's own expectation of the next write address.
    logic              busy_d;
    logic [ADDR_W-1:0] exp_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_d   <= 1'b0;
            exp_addr <= '0;
        end else begin
            busy_d <= busy;
            if (busy && !busy_d) begin
                exp_addr <= '0;
            end else if (ram_we) begin
                exp_addr <= exp_addr + 1'b1;
            end
        end
    end

    // R0
    p_reset_quiet_r0: assert property (@(posedge clk)
        rst |=> (!ram_we && !busy && !jump_pulse));

    p_start_gate_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(boot_mode) && $past(start)));

    p_addr_order_r3: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (ram_addr == exp_addr));

    p_write_src_r4: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> ($past(rx_valid) && $past(boot_mode) && ram_wdata == $past(rx_data)));

    p_jump_cause_r5: assert property (@(posedge clk) disable iff (rst)
        jump_pulse |-> ($past(ram_we) && $past(ram_addr) == TOP_ADDR));

    p_jump_after_top_r5: assert property (@(posedge clk) disable iff (rst)
        (ram_we && ram_addr == TOP_ADDR) |=> jump_pulse);

    p_jump_single_r5: assert property (@(posedge clk) disable iff (rst)
        jump_pulse |=> !jump_pulse);

    p_busy_drop_r6: assert property (@(posedge clk) disable iff (rst)
        jump_pulse |-> (!busy && $past(busy)));

    p_idle_no_write_r7: assert property (@(posedge clk) disable iff (rst)
        !busy |=> !ram_we);

    p_mode_drop_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !boot_mode) |=> !busy);

    p_abort_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !boot_mode && !ram_we) |=> (!jump_pulse && !ram_we));
endmodule

bind boot_ram_loader boot_ram_loader_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_boot_ram_loader.sv
`timescale 1ns/1ps
module test_boot_ram_loader;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int NBYTES = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              boot_mode = 1'b0;
    logic              start = 1'b0;
    logic              rx_valid = 1'b0;
    logic [DATA_W-1:0] rx_data = '0;
    logic [ADDR_W-1:0] ram_addr;
    logic [DATA_W-1:0] ram_wdata;
    logic              ram_we;
    logic              busy;
    logic              jump_pulse;

    always #2.5 clk = ~clk;

    boot_ram_loader #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_boot_ram_loader (
        .clk(clk), .rst(rst), .boot_mode(boot_mode), .start(start),
        .rx_valid(rx_valid), .rx_data(rx_data), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_we(ram_we), .busy(busy), .jump_pulse(jump_pulse)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [DATA_W-1:0] shadow [NBYTES];

    always @(negedge clk) if (ram_we) shadow[ram_addr] = ram_wdata;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    function automatic logic [DATA_W-1:0] img_byte(input int salt, input int idx);
        return DATA_W'((idx * 37) ^ salt ^ (idx >> 3));
    endfunction

    // At a negedge: pulse start, then check busy one cycle later.
    task automatic do_start(input bit expect_busy, input string req);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == expect_busy, req, busy, expect_busy);
    endtask

    // At a negedge: present one byte, check its write, then idle for gap cycles.
    task automatic send(input logic [DATA_W-1:0] d, input int idx, input int gap, input bit poke_start);
        rx_valid = 1'b1;
        rx_data  = d;
        @(negedge clk);
        rx_valid = 1'b0;
        rx_data  = DATA_W'($urandom);
        chk(ram_we == 1'b1, "R4 write strobe after byte", ram_we, 1);
        chk(ram_addr == ADDR_W'(idx), "R3 consecutive address", ram_addr, idx);
        chk(ram_wdata == d, "R4 written data", ram_wdata, d);
        if (idx < NBYTES - 1) chk(busy && !jump_pulse, "R2 busy during load", busy, 1);
        for (int g = 0; g < gap; g++) begin
            if (poke_start && g == 0) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(ram_we == 1'b0, "R4 no write without byte", ram_we, 0);
            if (poke_start) chk(busy == 1'b1, "R8 start during load ignored", busy, 1);
        end
    endtask

    task automatic full_load(input int salt, input int max_gap, input int poke_idx, input bit hold_last);
        int mism;
        do_start(1'b1, "R1 start in bootstrap mode");
        for (int i = 0; i < NBYTES; i++) begin
            int g;
            g = (max_gap == 0) ? 0 : int'($urandom_range(max_gap, 0));
            if (i == poke_idx && g == 0) g = 1;
            if (i == NBYTES - 1) g = 0;
            send(img_byte(salt, i), i, g, i == poke_idx);
        end
        if (hold_last) rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        chk(jump_pulse == 1'b1, "R5 handoff after top write", jump_pulse, 1);
        chk(busy == 1'b0, "R6 busy falls with handoff", busy, 0);
        chk(ram_we == 1'b0, "R7 no write during final cycle", ram_we, 0);
        @(negedge clk);
        chk(jump_pulse == 1'b0, "R5 handoff lasts one cycle", jump_pulse, 0);
        mism = 0;
        for (int a = 0; a < NBYTES; a++) if (shadow[a] !== img_byte(salt, a)) mism++;
        chk(mism == 0, "R3 whole image in RAM", mism, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!ram_we && !busy && !jump_pulse, "R0 outputs low in reset",
            {ram_we, busy, jump_pulse}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!ram_we && !busy && !jump_pulse, "R0 outputs low after reset",
            {ram_we, busy, jump_pulse}, 0);

        // Start outside bootstrap mode, and stray bytes while idle.
        do_start(1'b0, "R1 start ignored outside bootstrap mode");
        boot_mode = 1'b1;
        rx_valid  = 1'b1;
        rx_data   = 8'hA5;
        repeat (2) begin
            @(negedge clk);
            chk(ram_we == 1'b0, "R7 idle byte ignored", ram_we, 0);
        end
        rx_valid = 1'b0;
        @(negedge clk);

        // Full load with random gaps and a start poked in mid-load.
        full_load(int'($urandom_range(255, 0)), 3, 100, 1'b0);

        // Stray bytes after the handoff.
        rx_valid = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(ram_we == 1'b0 && busy == 1'b0, "R7 byte after handoff ignored", ram_we, 0);
        end
        rx_valid = 1'b0;
        @(negedge clk);

        // Abort by mode drop after a few bytes.
        do_start(1'b1, "R1 start for abort case");
        for (int i = 0; i < 5; i++) send(img_byte(7, i), i, 0, 1'b0);
        boot_mode = 1'b0;
        rx_valid  = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        chk(busy == 1'b0, "R9 mode drop ends load", busy, 0);
        chk(ram_we == 1'b0, "R9 no write on mode drop", ram_we, 0);
        repeat (3) begin
            @(negedge clk);
            chk(jump_pulse == 1'b0, "R9 no handoff after abort", jump_pulse, 0);
        end
        boot_mode = 1'b1;
        @(negedge clk);

        // Back-to-back load restarting at zero, stray byte held during final write.
        full_load(int'($urandom_range(255, 0)), 0, -1, 1'b1);

        repeat (2) @(negedge clk);
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            summary();
            $finish;
        end
    end
endmodule